// File: doc/BRIEF.md
# Programmable-Length Serial Pattern Generator

This block is a test-stimulus source. Software fills a 1024-bit pattern store through a small 16-bit register port. Each word written to the pattern address pushes every stored bit 16 places toward the top and drops the new word into the lowest 16 bits. A separate control register holds a 10-bit length. That length picks how many of the lowest store bits make up the repeating pattern.

Each pulse of `strobe` moves one pattern bit to the registered serial output. Playback starts at bit 0, the least significant bit of the newest word, and steps upward. After the last bit inside the programmed length it wraps back to bit 0. Store bits at or above the length never reach the output. Writing either register sends playback back to bit 0, so new settings always start from the beginning of the pattern.

Top module: `pg_top`

## Requirements
- R1: While `rst` is high and in the cycle after it, `sout` is 0. The length is 0 and the store is all zeros, so a read of the control address returns 0x0000.
- R2: A write to address 0x1A shifts the store up by 16 bit positions, discarding the top 16 bits. The written word lands in store bits 15..0.
- R3: Reads return 0x0000 combinationally for address 0x1A and for every address other than 0x19. A write to an address other than 0x19 or 0x1A changes no state.
- R4: A write to address 0x19 loads `wdata[9:0]` as the pattern length and ignores `wdata[15:10]`. A read of 0x19 returns the length in bits 9..0, with bits 15..10 reading 0.
- R5: With length N > 0 and no register write in the cycle, a `strobe` loads store bit `idx` into `sout` on that clock edge. The index then advances by one, and from N-1 it wraps to 0. The output therefore repeats store bits 0..N-1 in order.
- R6: With length 0, a `strobe` drives `sout` to 0 and keeps the index at 0.
- R7: A write to 0x19 or 0x1A resets the index to 0. A `strobe` in the same cycle as such a write is ignored and leaves `sout` unchanged.
- R8: In a cycle without an accepted `strobe`, `sout` keeps its value.
- R9: The index always stays below the length, so store bits at positions of N and above never reach `sout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational, 0 when not reading |
| strobe | input | 1 | Advance playback by one bit |
| sout | output | 1 | Registered serial pattern bit |

## Verification
The bench attacks the wrap point at three lengths: 1, a word-aligned 64, and the full 1023. An off-by-one index would either replay one bit of the unused region or drop the last bit of the pattern, and the per-strobe output compare catches both. It sets garbage bits above the length, and it sets junk in the upper control bits. A design that decoded the upper control bits would play the wrong length. A design that ignored the length would leak that region onto `sout`. It also collides a write with a strobe and writes the register mid-pattern: a design that let the strobe through or failed to restart would emit a stale bit or resume mid-pattern. Finally it covers length 0, reads of the write-only and unmapped addresses, and a long random mix of all of these.

// File: rtl/pg_pkg.sv
package pg_pkg;

    localparam int unsigned PG_WORD_W = 16;
    localparam int unsigned PG_CNT_W  = 10;
    localparam int unsigned PG_ADDR_W = 8;
    localparam int unsigned PG_DEPTH  = 1 << PG_CNT_W;
    localparam int unsigned PG_NWORDS = PG_DEPTH / PG_WORD_W;

    localparam logic [PG_ADDR_W-1:0] PG_CTRL_ADDR = 8'h19;
    localparam logic [PG_ADDR_W-1:0] PG_PAT_ADDR  = 8'h1A;

    typedef logic [PG_CNT_W-1:0]  pg_idx_t;
    typedef logic [PG_WORD_W-1:0] pg_word_t;
    typedef logic [PG_ADDR_W-1:0] pg_addr_t;

    typedef enum logic [1:0] {
        PG_TGT_NONE,
        PG_TGT_CTRL,
        PG_TGT_PAT
    } pg_tgt_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        pg_addr_t addr;
        pg_word_t data;
    } pg_req_t;

    typedef struct packed {
        pg_idx_t idx;
        logic    bit_out;
    } pg_play_t;

    // Next playback index for a nonzero length.
    function automatic pg_idx_t pg_advance(pg_idx_t idx, pg_idx_t len);
        return (idx >= len - pg_idx_t'(1)) ? '0 : idx + pg_idx_t'(1);
    endfunction

    // Read view of the control register.
    function automatic pg_word_t pg_ctrl_view(pg_idx_t len);
        return pg_word_t'(len);
    endfunction

endpackage

// File: rtl/pg_regs.sv
module pg_regs
    import pg_pkg::*;
#(
    parameter pg_addr_t CTRL_ADDR = PG_CTRL_ADDR,
    parameter pg_addr_t PAT_ADDR  = PG_PAT_ADDR
) (
    input  logic     clk,
    input  logic     rst,
    input  pg_req_t  req,
    output pg_idx_t  len,
    output logic     pat_push,
    output logic     restart,
    output pg_word_t rdata
);

    pg_tgt_e tgt;
    pg_idx_t len_q;

    always_comb begin
        if (req.addr == CTRL_ADDR)     tgt = PG_TGT_CTRL;
        else if (req.addr == PAT_ADDR) tgt = PG_TGT_PAT;
        else                           tgt = PG_TGT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst)                                  len_q <= '0;
        else if (req.wr && tgt == PG_TGT_CTRL)    len_q <= req.data[PG_CNT_W-1:0];
    end

    assign len      = len_q;
    assign pat_push = req.wr && (tgt == PG_TGT_PAT);
    assign restart  = req.wr && (tgt != PG_TGT_NONE);

    always_comb begin
        rdata = '0;
        if (req.rd && tgt == PG_TGT_CTRL) rdata = pg_ctrl_view(len_q);
    end

endmodule

// File: rtl/pg_store.sv
module pg_store
    import pg_pkg::*;
#(
    parameter int unsigned NWORDS = PG_NWORDS,
    localparam int unsigned BITS  = NWORDS * PG_WORD_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  pg_word_t        din,
    output logic [BITS-1:0] bits
);

    pg_word_t words [NWORDS];

    generate
        for (genvar w = 0; w < NWORDS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst)       words[w] <= '0;
                else if (push) words[w] <= (w == 0) ? din : words[(w == 0) ? 0 : w - 1];
            end
            assign bits[w*PG_WORD_W +: PG_WORD_W] = words[w];
        end
    endgenerate

endmodule

// File: rtl/pg_player.sv
module pg_player
    import pg_pkg::*;
#(
    parameter int unsigned DEPTH = PG_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             restart,
    input  pg_idx_t          len,
    input  logic [DEPTH-1:0] bits,
    output pg_play_t         state
);

    pg_play_t st_q;
    pg_play_t st_d;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.idx = '0;
        end else if (strobe) begin
            if (len == '0) begin
                st_d.idx     = '0;
                st_d.bit_out = 1'b0;
            end else begin
                st_d.bit_out = bits[st_q.idx];
                st_d.idx     = pg_advance(st_q.idx, len);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign state = st_q;

endmodule

// File: rtl/pg_top.sv
module pg_top
    import pg_pkg::*;
#(
    parameter pg_addr_t CTRL_ADDR = PG_CTRL_ADDR,
    parameter pg_addr_t PAT_ADDR  = PG_PAT_ADDR
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic        strobe,
    output logic        sout
);

    pg_req_t             req;
    pg_idx_t             len_q;
    pg_idx_t             play_idx;
    logic                pat_push;
    logic                restart;
    logic [PG_DEPTH-1:0] store_bits;
    pg_play_t            play_st;

    assign req = '{wr: wr_en, rd: rd_en, addr: addr, data: wdata};

    pg_regs #(.CTRL_ADDR(CTRL_ADDR), .PAT_ADDR(PAT_ADDR)) u_regs (
        .clk(clk), .rst(rst), .req(req), .len(len_q),
        .pat_push(pat_push), .restart(restart), .rdata(rdata)
    );

    pg_store #(.NWORDS(PG_NWORDS)) u_store (
        .clk(clk), .rst(rst), .push(pat_push), .din(wdata), .bits(store_bits)
    );

    pg_player #(.DEPTH(PG_DEPTH)) u_player (
        .clk(clk), .rst(rst), .strobe(strobe), .restart(restart),
        .len(len_q), .bits(store_bits), .state(play_st)
    );

    assign play_idx = play_st.idx;
    assign sout     = play_st.bit_out;

endmodule

// File: rtl/pg_chk.sv
module pg_chk
    import pg_pkg::*;
#(
    parameter pg_addr_t CTRL_ADDR = PG_CTRL_ADDR,
    parameter pg_addr_t PAT_ADDR  = PG_PAT_ADDR
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        rd_en,
    input logic [7:0]  addr,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic        strobe,
    input logic        sout,
    input pg_idx_t     len,
    input pg_idx_t     idx
);

    logic hit;
    assign hit = (addr == CTRL_ADDR) || (addr == PAT_ADDR);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!sout && idx == '0 && len == '0));

    // R3
    pat_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr != CTRL_ADDR) |-> rdata == 16'h0000);

    // R4
    len_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CTRL_ADDR) |=> len == $past(wdata[PG_CNT_W-1:0]));

    // R6
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (len == '0 && strobe && !(wr_en && hit)) |=> !sout);

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit) |=> (idx == '0 && $stable(sout)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(sout));

    // R9
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        (len == '0) ? (idx == '0) : (idx < len));

endmodule

bind pg_top pg_chk #(.CTRL_ADDR(CTRL_ADDR), .PAT_ADDR(PAT_ADDR)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .strobe(strobe), .sout(sout),
    .len(len_q), .idx(play_idx)
);

// File: tb/tb_pg_top.sv
`timescale 1ns/1ps
module tb_pg_top;

    localparam logic [7:0] A_CTRL = 8'h19;
    localparam logic [7:0] A_PAT  = 8'h1A;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en, strobe;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        sout;

    always #2 clk = ~clk;

    pg_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .strobe(strobe), .sout(sout)
    );

    logic [1023:0] m_store;
    logic [9:0]    m_len;
    logic [9:0]    m_idx;
    logic          m_sout;
    int            n_tests = 0;
    int            n_fail  = 0;
    bit            done    = 1'b0;

    function automatic logic [15:0] exp_read(logic [7:0] a, logic [9:0] len);
        return (a == A_CTRL) ? {6'b0, len} : 16'h0000;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit wr, input bit rd, input logic [7:0] a,
                       input logic [15:0] d, input bit stb, input string tag);
        bit hit;
        @(negedge clk);
        wr_en = wr; rd_en = rd; addr = a; wdata = d; strobe = stb;
        #1;
        if (rd) check(rdata == exp_read(a, m_len), (a == A_CTRL) ? "R4" : "R3", rdata, exp_read(a, m_len));
        @(posedge clk);
        hit = (a == A_CTRL) || (a == A_PAT);
        if (wr && hit) begin
            if (a == A_CTRL) m_len = d[9:0];
            else             m_store = {m_store[1007:0], d};
            m_idx = '0;
        end else if (stb) begin
            if (m_len == 0) begin
                m_sout = 1'b0; m_idx = '0;
            end else begin
                m_sout = m_store[m_idx];
                m_idx  = (m_idx == m_len - 10'd1) ? 10'd0 : m_idx + 10'd1;
            end
        end
        #1;
        check(sout == m_sout, tag, {15'b0, sout}, {15'b0, m_sout});
    endtask

    task automatic idle_in();
        wr_en = 0; rd_en = 0; addr = 8'h00; wdata = 16'h0; strobe = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_in();
        rst = 1'b1;
        m_store = '0; m_len = '0; m_idx = '0; m_sout = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        check(sout == 1'b0, "R1", {15'b0, sout}, 16'h0);
        cyc(0, 1, A_CTRL, 16'h0, 0, "R1");
        cyc(0, 0, 8'h0, 16'h0, 1, "R1");

        // R2: load four words, then R4 length with junk upper bits
        cyc(1, 0, A_PAT, 16'hA5C3, 0, "R2");
        cyc(1, 0, A_PAT, 16'h0FF0, 0, "R2");
        cyc(1, 0, A_PAT, 16'h1234, 0, "R2");
        cyc(1, 0, A_PAT, 16'hBEEF, 0, "R2");
        cyc(1, 0, A_CTRL, 16'hFC40, 0, "R4");
        cyc(0, 1, A_CTRL, 16'h0, 0, "R4");
        // R3: write-only and unmapped reads, unmapped write
        cyc(0, 1, A_PAT, 16'h0, 0, "R3");
        cyc(0, 1, 8'h00, 16'h0, 0, "R3");
        cyc(1, 0, 8'h1B, 16'hFFFF, 0, "R3");
        cyc(0, 1, A_CTRL, 16'h0, 0, "R3");
        // R5: play past wrap at 64
        for (int i = 0; i < 140; i++) cyc(0, 0, 8'h0, 16'h0, 1, "R5");
        // R8: hold without strobe
        for (int i = 0; i < 6; i++) cyc(0, 0, 8'h0, 16'h0, 0, "R8");
        // R9: short length, upper bits must not leak
        cyc(1, 0, A_CTRL, 16'd5, 0, "R9");
        for (int i = 0; i < 20; i++) cyc(0, 0, 8'h0, 16'h0, 1, "R9");
        cyc(1, 0, A_CTRL, 16'd1, 0, "R9");
        for (int i = 0; i < 6; i++) cyc(0, 0, 8'h0, 16'h0, 1, "R9");
        // R7: mid-pattern write collides with a strobe
        cyc(1, 0, A_CTRL, 16'd37, 0, "R7");
        for (int i = 0; i < 9; i++) cyc(0, 0, 8'h0, 16'h0, 1, "R7");
        cyc(1, 0, A_PAT, 16'h6B2D, 1, "R7");
        for (int i = 0; i < 9; i++) cyc(0, 0, 8'h0, 16'h0, 1, "R7");
        cyc(1, 0, A_CTRL, 16'd37, 1, "R7");
        for (int i = 0; i < 4; i++) cyc(0, 0, 8'h0, 16'h0, 1, "R7");
        // R6: length zero
        cyc(1, 0, A_CTRL, 16'h0, 0, "R6");
        for (int i = 0; i < 5; i++) cyc(0, 0, 8'h0, 16'h0, 1, "R6");
        // R5: full store, maximum length
        for (int i = 0; i < 64; i++) cyc(1, 0, A_PAT, 16'($urandom), 0, "R2");
        cyc(1, 0, A_CTRL, 16'd1023, 0, "R5");
        for (int i = 0; i < 1100; i++) cyc(0, 0, 8'h0, 16'h0, 1, "R5");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            logic [7:0]  a;
            logic [15:0] d;
            bit          wr, rd;
            r  = $urandom_range(0, 99);
            a  = (r < 40) ? A_PAT : (r < 70) ? A_CTRL : 8'($urandom);
            d  = (a == A_CTRL) ? 16'($urandom_range(0, 90)) | (16'($urandom) & 16'hFC00) : 16'($urandom);
            wr = ($urandom_range(0, 99) < 6);
            rd = ($urandom_range(0, 99) < 20);
            cyc(wr, rd, a, d, $urandom_range(0, 99) < 75, wr ? "R7" : "R5");
        end
        idle_in();
        finish_run();
    end

endmodule